// File: doc/BRIEF.md
# Soft Reset and FIFO Flush Controller

This block owns the control word through which software resets parts of a bus-attached controller core and empties its data queues. One write can request one of these actions: a full soft reset of the core, a soft reset of only the bus-clock-domain logic, a flush of a chosen transmit FIFO, a flush of the receive FIFO, a flush of the token-learning queue, or a clear of the frame counter. Each request raises a bit that software can poll. The bit clears by itself once the action is over. The block also drives the matching strobe or reset level toward the logic that does the work.

The FIFOs, the frame counter and the state machines being reset sit outside this block. It sees them only through done inputs for the two soft resets and a start-of-frame event for the frame clear. Flushes last a fixed number of cycles. A soft reset lasts a minimum number of cycles and then waits for its done input. The same word also reports two live status inputs: whether the bus master is idle, and whether a DMA request is in flight.

Top module: `softreset_flush_ctl`

## Requirements
- R1: A write with bit 0 set, while no transmit flush is pending and no soft reset is active, gives a one-cycle pulse on `txf_flush_o` in the cycle after the write. In that cycle `txf_sel_o` carries the written FIFO number from bits 12:8 (0 non-periodic, 1 to 15 periodic, 16 all).
- R2: Read bit 0 is 1 for exactly FLUSH_CYCLES (default 8) cycles from the cycle after an accepted transmit flush write, then reads 0. Writing bit 0 again while it is set does not restart the count.
- R3: The FIFO number (read bits 12:8) takes the written value on any accepted write that starts no soft reset. While read bit 0 is 1, writes leave the field unchanged.
- R4: The receive flush behaves as R1 and R2, using bit 1 and `rxf_flush_o`, and runs independently of the transmit flush.
- R5: A write with bit 2 set gives a one-cycle pulse on `tokq_flush_o` in the next cycle. Read bit 2 is 1 in that same cycle only.
- R6: A write with bit 3 set, when read bit 3 is 0, gives a one-cycle pulse on `frame_clr_o` and sets read bit 3. Read bit 3 stays 1 until a cycle with `sof_i` high. Further writes of bit 3 while it is set give no pulse.
- R7: A write with bit 5 set raises `core_rst_o` and read bit 5 from the next cycle. Both stay high for at least MIN_HOLD (default 4) cycles. They fall in the cycle after the first cycle in which that minimum is met and `core_done_i` is high.
- R8: Starting a core soft reset pulses `txf_flush_o` (with `txf_sel_o` = 16), `rxf_flush_o` and `tokq_flush_o` once. It cancels any pending transmit or receive flush and any pending frame clear, and sets the FIFO number to 0.
- R9: A write with bit 4 set raises `bus_rst_o` and read bit 4 under the hold rule of R7, using `bus_done_i`. It emits no flush pulse and does not disturb a flush that is already pending.
- R10: While `core_rst_o` or `bus_rst_o` is high, every write is ignored. A write with both bits 5 and 4 set starts only the core reset. A write that starts either reset ignores all of its other bits.
- R11: Read bit 31 equals `master_idle_i` and read bit 30 equals `dma_req_i` in the same cycle. Bits 29:13 and 7:6 read 0.
- R12: After reset every output is 0, apart from the status bits of R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Value written |
| rd_data_o | output | 32 | Current control and status word |
| master_idle_i | input | 1 | Bus master state machine is idle |
| dma_req_i | input | 1 | DMA request in progress |
| core_done_i | input | 1 | Core reset work complete |
| bus_done_i | input | 1 | Bus-domain reset work complete |
| sof_i | input | 1 | Start-of-frame sent |
| core_rst_o | output | 1 | Core soft reset level |
| bus_rst_o | output | 1 | Bus-domain soft reset level |
| txf_flush_o | output | 1 | Transmit flush strobe |
| txf_sel_o | output | 5 | Transmit FIFO targeted by the strobe |
| rxf_flush_o | output | 1 | Receive flush strobe |
| tokq_flush_o | output | 1 | Token queue flush strobe |
| frame_clr_o | output | 1 | Frame counter clear strobe |

## Verification
Nearly all internal state is visible in the read word, so a wrong state shows in the cycle after it forms. A flush countdown that is off by one moves the falling edge of bit 0 or bit 1. A hold counter that fails to saturate keeps `core_rst_o` high past the done input. A missed cancel leaves a busy bit set while a reset is active. Strobes are compared every cycle, so a pulse that comes late or is doubled shows one cycle after the write that caused it.

// File: rtl/srfc_pkg.sv
`timescale 1ns/1ps
package srfc_pkg;
  localparam int REG_W    = 32;
  localparam int TXF_BIT  = 0;
  localparam int RXF_BIT  = 1;
  localparam int TOK_BIT  = 2;
  localparam int FRM_BIT  = 3;
  localparam int BUS_BIT  = 4;
  localparam int CORE_BIT = 5;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 5;
  localparam int DMA_BIT  = 30;
  localparam int IDLE_BIT = 31;

  typedef logic [SEL_W-1:0] fifo_sel_t;

  typedef struct packed {
    logic core;
    logic bus;
    logic frm;
    logic tok;
    logic rxf;
    logic txf;
  } req_t;

  // code that addresses every transmit FIFO at once
  function automatic fifo_sel_t all_fifos_code();
    return fifo_sel_t'(1) << (SEL_W - 1);
  endfunction

  function automatic fifo_sel_t sel_field(input logic [REG_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  function automatic req_t decode_req(input logic [REG_W-1:0] w);
    req_t r;
    r.core = w[CORE_BIT];
    r.bus  = w[BUS_BIT];
    r.frm  = w[FRM_BIT];
    r.tok  = w[TOK_BIT];
    r.rxf  = w[RXF_BIT];
    r.txf  = w[TXF_BIT];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic      idle,
    input logic      dma,
    input fifo_sel_t sel,
    input req_t      live
  );
    logic [REG_W-1:0] w;
    w = '0;
    w[IDLE_BIT]             = idle;
    w[DMA_BIT]              = dma;
    w[SEL_LSB +: SEL_W]     = sel;
    w[CORE_BIT]             = live.core;
    w[BUS_BIT]              = live.bus;
    w[FRM_BIT]              = live.frm;
    w[TOK_BIT]              = live.tok;
    w[RXF_BIT]              = live.rxf;
    w[TXF_BIT]              = live.txf;
    return w;
  endfunction
endpackage

// File: rtl/srfc_flush_timer.sv
`timescale 1ns/1ps
module srfc_flush_timer #(
  parameter int FLUSH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o
);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(FLUSH_CYCLES);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (abort_i)         left_q <= '0;
    else if (start_i)         left_q <= LOAD;
    else if (left_q != '0)    left_q <= left_q - CW'(1);
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/srfc_reset_seq.sv
`timescale 1ns/1ps
module srfc_reset_seq #(
  parameter int MIN_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic active_o,
  output logic release_o
);
  localparam int HW = $clog2(MIN_HOLD) + 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_HOLD - 1);

  logic          active_q;
  logic [HW-1:0] held_q;

  assign release_o = active_q && (held_q == HOLD_LAST) && done_i;
  assign active_o  = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      held_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      held_q   <= '0;
    end else if (release_o) begin
      active_q <= 1'b0;
      held_q   <= '0;
    end else if (active_q && held_q != HOLD_LAST) begin
      held_q   <= held_q + HW'(1);
    end
  end
endmodule

// File: rtl/srfc_req_arb.sv
`timescale 1ns/1ps
module srfc_req_arb
  import srfc_pkg::*;
(
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             core_act_i,
  input  logic             bus_act_i,
  input  logic             txf_busy_i,
  input  logic             rxf_busy_i,
  input  logic             frm_pend_i,
  output logic             core_start_o,
  output logic             bus_start_o,
  output logic             txf_start_o,
  output logic             rxf_start_o,
  output logic             tok_start_o,
  output logic             frm_start_o,
  output logic             sel_load_o
);
  req_t req;
  logic accept;
  logic plain;

  always_comb begin
    req          = decode_req(wr_data_i);
    accept       = wr_en_i && !core_act_i && !bus_act_i;
    plain        = accept && !req.core && !req.bus;
    core_start_o = accept && req.core;
    bus_start_o  = accept && req.bus && !req.core;
    txf_start_o  = plain && req.txf && !txf_busy_i;
    rxf_start_o  = plain && req.rxf && !rxf_busy_i;
    tok_start_o  = plain && req.tok;
    frm_start_o  = plain && req.frm && !frm_pend_i;
    sel_load_o   = plain && !txf_busy_i;
  end
endmodule

// File: rtl/softreset_flush_ctl.sv
`timescale 1ns/1ps
module softreset_flush_ctl
  import srfc_pkg::*;
#(
  parameter int FLUSH_CYCLES = 8,
  parameter int MIN_HOLD     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             master_idle_i,
  input  logic             dma_req_i,
  input  logic             core_done_i,
  input  logic             bus_done_i,
  input  logic             sof_i,
  output logic             core_rst_o,
  output logic             bus_rst_o,
  output logic             txf_flush_o,
  output logic [SEL_W-1:0] txf_sel_o,
  output logic             rxf_flush_o,
  output logic             tokq_flush_o,
  output logic             frame_clr_o
);
  localparam int N_FLUSH = 2;   // 0: transmit, 1: receive
  localparam int N_RESET = 2;   // 0: core, 1: bus domain

  // named internal events
  logic core_start, bus_start, txf_start, rxf_start, tok_start, frm_start, sel_load;
  logic core_release, bus_release;

  logic [N_FLUSH-1:0] fl_start, fl_busy;
  logic [N_RESET-1:0] rs_start, rs_done, rs_act, rs_rel;

  fifo_sel_t sel_q, tgt_q;
  logic      txp_q, rxp_q, tokp_q, frmp_q, frm_pend_q;
  req_t      live;

  srfc_req_arb u_arb (
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .core_act_i  (rs_act[0]),
    .bus_act_i   (rs_act[1]),
    .txf_busy_i  (fl_busy[0]),
    .rxf_busy_i  (fl_busy[1]),
    .frm_pend_i  (frm_pend_q),
    .core_start_o(core_start),
    .bus_start_o (bus_start),
    .txf_start_o (txf_start),
    .rxf_start_o (rxf_start),
    .tok_start_o (tok_start),
    .frm_start_o (frm_start),
    .sel_load_o  (sel_load)
  );

  assign fl_start = {rxf_start, txf_start};

  for (genvar g = 0; g < N_FLUSH; g++) begin : g_flush
    srfc_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(fl_start[g]),
      .abort_i(core_start),
      .busy_o (fl_busy[g])
    );
  end

  assign rs_start = {bus_start, core_start};
  assign rs_done  = {bus_done_i, core_done_i};

  for (genvar g = 0; g < N_RESET; g++) begin : g_reset
    srfc_reset_seq #(.MIN_HOLD(MIN_HOLD)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (rs_start[g]),
      .done_i   (rs_done[g]),
      .active_o (rs_act[g]),
      .release_o(rs_rel[g])
    );
  end

  assign core_release = rs_rel[0];
  assign bus_release  = rs_rel[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      tgt_q      <= '0;
      txp_q      <= 1'b0;
      rxp_q      <= 1'b0;
      tokp_q     <= 1'b0;
      frmp_q     <= 1'b0;
      frm_pend_q <= 1'b0;
    end else begin
      txp_q  <= txf_start || core_start;
      rxp_q  <= rxf_start || core_start;
      tokp_q <= tok_start || core_start;
      frmp_q <= frm_start;

      if (core_start)      tgt_q <= all_fifos_code();
      else if (txf_start)  tgt_q <= sel_field(wr_data_i);

      if (core_start)      sel_q <= '0;
      else if (sel_load)   sel_q <= sel_field(wr_data_i);

      if (core_start)      frm_pend_q <= 1'b0;
      else if (frm_start)  frm_pend_q <= 1'b1;
      else if (sof_i)      frm_pend_q <= 1'b0;
    end
  end

  always_comb begin
    live.core = rs_act[0];
    live.bus  = rs_act[1];
    live.frm  = frm_pend_q;
    live.tok  = tokp_q;
    live.rxf  = fl_busy[1];
    live.txf  = fl_busy[0];
  end

  assign rd_data_o    = pack_status(master_idle_i, dma_req_i, sel_q, live);
  assign core_rst_o   = rs_act[0];
  assign bus_rst_o    = rs_act[1];
  assign txf_flush_o  = txp_q;
  assign txf_sel_o    = tgt_q;
  assign rxf_flush_o  = rxp_q;
  assign tokq_flush_o = tokp_q;
  assign frame_clr_o  = frmp_q;
endmodule

// File: rtl/srfc_chk.sv
`timescale 1ns/1ps
module srfc_chk #(
  parameter int FLUSH_CYCLES = 8,
  parameter int MIN_HOLD     = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        txf_flush,
  input logic [4:0]  txf_sel,
  input logic        rxf_flush,
  input logic        core_rst,
  input logic        bus_rst,
  input logic        core_done,
  input logic        bus_done,
  input logic        frame_clr,
  input logic        core_release
);
  int tx_len, core_len, bus_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_len <= 0; core_len <= 0; bus_len <= 0;
    end else begin
      tx_len   <= rd_data[0] ? tx_len + 1 : 0;
      core_len <= core_rst ? ((core_len < MIN_HOLD) ? core_len + 1 : core_len) : 0;
      bus_len  <= bus_rst  ? ((bus_len  < MIN_HOLD) ? bus_len  + 1 : bus_len)  : 0;
    end
  end

  // R1
  txf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> txf_flush);
  // R2
  txf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_data[0]) && !core_rst) |-> (tx_len == FLUSH_CYCLES));
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && $past(rd_data[0])) |-> $stable(rd_data[12:8]));
  // R6
  frame_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |-> rd_data[3]);
  // R7
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (core_len >= MIN_HOLD && $past(core_done)));
  // R7
  core_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |=> !core_rst);
  // R8
  core_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> (txf_flush && rxf_flush && txf_sel == 5'd16));
  // R8
  core_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!rd_data[0] && !rd_data[1] && !rd_data[3]));
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rst) |-> (bus_len >= MIN_HOLD && $past(bus_done)));
  // R9
  bus_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst) |-> (!txf_flush && !rxf_flush));
  // R10
  reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_rst && bus_rst));
endmodule

bind softreset_flush_ctl srfc_chk #(.FLUSH_CYCLES(FLUSH_CYCLES), .MIN_HOLD(MIN_HOLD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_data     (rd_data_o),
  .txf_flush   (txf_flush_o),
  .txf_sel     (txf_sel_o),
  .rxf_flush   (rxf_flush_o),
  .core_rst    (core_rst_o),
  .bus_rst     (bus_rst_o),
  .core_done   (core_done_i),
  .bus_done    (bus_done_i),
  .frame_clr   (frame_clr_o),
  .core_release(core_release)
);

// File: tb/sim_softreset_flush_ctl.sv
`timescale 1ns/1ps
module sim_softreset_flush_ctl;
  localparam int FLUSH = 8;
  localparam int HOLD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        idle = 1'b1, dma = 1'b0, core_done = 1'b1, bus_done = 1'b1, sof = 1'b0;
  logic        core_rst, bus_rst, txf_flush, rxf_flush, tokq_flush, frame_clr;
  logic [4:0]  txf_sel;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  softreset_flush_ctl #(.FLUSH_CYCLES(FLUSH), .MIN_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .master_idle_i(idle), .dma_req_i(dma), .core_done_i(core_done), .bus_done_i(bus_done),
    .sof_i(sof), .core_rst_o(core_rst), .bus_rst_o(bus_rst), .txf_flush_o(txf_flush),
    .txf_sel_o(txf_sel), .rxf_flush_o(rxf_flush), .tokq_flush_o(tokq_flush),
    .frame_clr_o(frame_clr)
  );

  // behavioural reference state
  int m_tx, m_rx, m_core_n, m_bus_n;
  bit m_core, m_bus, m_frm, m_txp, m_rxp, m_tokp, m_frp;
  int m_sel, m_tgt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit acc, wc, wb, pl, ts, rs, ks, fs;
    int d_sel;
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_core_n = 0; m_bus_n = 0; m_core = 0; m_bus = 0; m_frm = 0;
      m_txp = 0; m_rxp = 0; m_tokp = 0; m_frp = 0; m_sel = 0; m_tgt = 0;
      return;
    end
    acc = wr_en && !m_core && !m_bus;
    wc  = acc && wr_data[5];
    wb  = acc && wr_data[4] && !wr_data[5];
    pl  = acc && !wr_data[5] && !wr_data[4];
    ts  = pl && wr_data[0] && (m_tx == 0);
    rs  = pl && wr_data[1] && (m_rx == 0);
    ks  = pl && wr_data[2];
    fs  = pl && wr_data[3] && !m_frm;
    d_sel = int'(wr_data[12:8]);
    m_txp = ts || wc; m_rxp = rs || wc; m_tokp = ks || wc; m_frp = fs;
    if (wc) m_tgt = 16; else if (ts) m_tgt = d_sel;
    if (wc) m_sel = 0; else if (pl && m_tx == 0) m_sel = d_sel;
    if (wc) m_frm = 0; else if (fs) m_frm = 1; else if (sof) m_frm = 0;
    if (wc) m_tx = 0; else if (ts) m_tx = FLUSH; else if (m_tx > 0) m_tx--;
    if (wc) m_rx = 0; else if (rs) m_rx = FLUSH; else if (m_rx > 0) m_rx--;
    if (wc) begin m_core = 1; m_core_n = 0; end
    else if (m_core) begin
      if (m_core_n >= HOLD - 1 && core_done) m_core = 0;
      else if (m_core_n < HOLD - 1) m_core_n++;
    end
    if (wb) begin m_bus = 1; m_bus_n = 0; end
    else if (m_bus) begin
      if (m_bus_n >= HOLD - 1 && bus_done) m_bus = 0;
      else if (m_bus_n < HOLD - 1) m_bus_n++;
    end
  endtask

  task automatic compare();
    chk("R2 txf busy bit", rd_data[0], m_tx > 0);
    chk("R4 rxf busy bit", rd_data[1], m_rx > 0);
    chk("R5 tok bit", rd_data[2], m_tokp);
    chk("R6 frame pending bit", rd_data[3], m_frm);
    chk("R9 bus reset bit", rd_data[4], m_bus);
    chk("R7 core reset bit", rd_data[5], m_core);
    chk("R3 fifo number", rd_data[12:8], m_sel);
    chk("R11 status bits", rd_data[31:30], {idle, dma});
    chk("R11 unused bits", {rd_data[29:13], rd_data[7:6]}, 0);
    chk("R1 txf strobe", txf_flush, m_txp);
    chk("R1 txf target", txf_sel, m_tgt);
    chk("R4 rxf strobe", rxf_flush, m_rxp);
    chk("R5 tok strobe", tokq_flush, m_tokp);
    chk("R6 frame strobe", frame_clr, m_frp);
    chk("R7 core_rst_o", core_rst, m_core);
    chk("R9 bus_rst_o", bus_rst, m_bus);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    step();
    // R12 reset state
    chk("R12 reset word", rd_data & 32'h3FFF_FFFF, 0);
    chk("R12 reset strobes", {core_rst, bus_rst, txf_flush, rxf_flush, tokq_flush, frame_clr}, 0);

    // transmit flush of FIFO 3
    wr(32'h0000_0301);
    chk("R1 pulse after write", {txf_flush, txf_sel}, {1'b1, 5'd3});
    run(2);
    wr(32'h0000_0701);   // R3: number write ignored, R2: no restart
    chk("R3 number held while busy", rd_data[12:8], 5'd3);
    chk("R2 no second pulse", txf_flush, 1'b0);
    run(8);
    wr(32'h0000_0900);
    chk("R3 number loaded when idle", rd_data[12:8], 5'd9);
    wr(32'h0000_1001);   // flush all
    chk("R1 all-fifo target", txf_sel, 5'd16);

    // receive, token, frame
    wr(32'h0000_0002);
    run(3);
    wr(32'h0000_0004);
    chk("R5 token pulse", tokq_flush, 1'b1);
    wr(32'h0000_0008);
    run(2);
    wr(32'h0000_0008);
    chk("R6 no repeat pulse", frame_clr, 1'b0);
    sof = 1'b1; step(); sof = 1'b0;
    chk("R6 cleared by sof", rd_data[3], 1'b0);
    run(8);
    idle = 1'b0; dma = 1'b1; step();
    idle = 1'b1; dma = 1'b0; step();

    // core reset cancels a pending flush, waits for done
    wr(32'h0000_0208);
    wr(32'h0000_0203);
    run(1);
    core_done = 1'b0;
    wr(32'h0000_0020);
    chk("R8 all-fifo flush target", txf_sel, 5'd16);
    chk("R8 flushes cancelled", rd_data[1:0], 2'b00);
    chk("R8 number cleared", rd_data[12:8], 5'd0);
    chk("R8 frame clear cancelled", rd_data[3], 1'b0);
    run(5);
    wr(32'h0000_0001);
    chk("R10 write ignored in core reset", {txf_flush, rd_data[0]}, 2'b00);
    core_done = 1'b1;
    run(3);
    chk("R7 released", core_rst, 1'b0);

    // core reset with done already high: minimum hold
    wr(32'h0000_0020);
    run(6);

    // bus reset leaves a pending receive flush alone
    wr(32'h0000_0002);
    bus_done = 1'b0;
    wr(32'h0000_0010);
    chk("R9 no flush strobes", {txf_flush, rxf_flush, tokq_flush}, 3'b000);
    chk("R9 rx flush continues", rd_data[1], 1'b1);
    run(4);
    bus_done = 1'b1;
    run(4);

    // both reset bits: core wins
    wr(32'h0000_0030);
    chk("R10 core wins", {core_rst, bus_rst}, 2'b10);
    run(6);
    // reset bit suppresses the other bits of the same write
    wr(32'h0000_0511);
    chk("R10 flush bits suppressed", {txf_flush, rd_data[0], rd_data[12:8]}, {2'b00, 5'd0});
    run(6);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule